// File: doc/BRIEF.md
# Paged Flash Boot Controller

This block sits beside an embedded configuration flash. It accepts word writes from a configuration port, decides from a signature word what the flash may be used for, guards byte reads, and copies the flash into a configuration SRAM when the device boots or is told to reload. The flash is built from X-pages of 256 bytes. Each X-page holds 64 Y-pages, and each Y-page is one 32-bit word. The host writes one Y-page per command. When a host image ends part way through a page, the host pads the rest of that page with 0xFF or 0x00 before writing it.

Readback and autoboot are not fixed options. They are controlled only by the word in Y-page 0 of X-page 0. One signature value opens byte reads. A second signature value turns on automatic loading. Any other value leaves reads blocked and autoboot off. The decoder looks at that word again each time it is written, after every reset, and after an erase. The copy engine moves one byte per cycle, from byte 0 up to the last configured byte, into the SRAM write port. While it copies it holds a busy output high, and when it finishes it pulses done.

Top module: `flash_boot_ctrl`

## Requirements
- R1: A write to (X-page x, Y-page y) stores the 32-bit word so that byte k, taken from bits [8k+7:8k], sits at byte address x*256 + y*4 + k. A byte read requested on `rd_en` returns its result in the following cycle.
- R2: When the word at byte addresses 0..3 holds the bytes 0x07, 0x07, 0x30, 0x40 in that order (word value 0x40300707), reads are granted. In the cycle after the request, `rd_valid` is high and `rd_data` equals the stored byte.
- R3: When that word holds the bytes 0x47, 0x57, 0x31, 0x4E in that order (word value 0x4E315747), autoboot is enabled and reads are refused.
- R4: A refused read gives `rd_data` = 0x00, `rd_valid` low and `rd_err` high for exactly the one cycle that answers that request.
- R5: Each accepted write to Y-page 0 of X-page 0 decodes the signature again. Writing any value other than a signature removes read access and autoboot from the next cycle on.
- R6: An accepted erase sets every flash byte to 0xFF and clears both the read and autoboot permissions.
- R7: After reset is released, word 0 is examined. If it holds the autoboot signature, copying starts without any command, and `boot_busy` first rises in the third cycle after release.
- R8: An accepted reprogram with autoboot enabled raises `boot_busy` in the next cycle. A write is issued on `cfg_we` in each of the following CFG_BYTES cycles, with `cfg_addr` running 0, 1, ... CFG_BYTES-1 in order and `cfg_data` equal to the flash byte at that address. `boot_busy` stays high up to and including the last write.
- R9: `boot_done` is high for exactly one cycle, in the cycle after the last SRAM write, and `boot_busy` is low in that cycle.
- R10: A reprogram request while autoboot is not enabled has no effect: no busy, no SRAM write, no done.
- R11: Configuration writes, erase requests and reprogram requests are ignored while the engine is not idle, that is, during the post-reset scan and during a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_wr_en | input | 1 | Write one Y-page word |
| pg_wr_xpage | input | XW | X-page index of the write |
| pg_wr_ypage | input | 6 | Y-page index within the X-page |
| pg_wr_data | input | 32 | Word to store, byte 0 in bits [7:0] |
| erase_req | input | 1 | Erase the whole flash |
| reprog_req | input | 1 | Request a flash-to-SRAM load |
| rd_en | input | 1 | Byte read request |
| rd_addr | input | AW | Byte address of the read |
| rd_valid | output | 1 | Granted read data present |
| rd_data | output | 8 | Read byte, zero when refused |
| rd_err | output | 1 | One-cycle pulse for a refused read |
| cfg_we | output | 1 | SRAM write strobe |
| cfg_addr | output | CW | SRAM byte address |
| cfg_data | output | 8 | SRAM write byte |
| boot_busy | output | 1 | Copy in progress |
| boot_done | output | 1 | One-cycle pulse at copy end |

## Verification
The signature word is driven through four distinct values: the read signature, the autoboot signature, an arbitrary non-signature word, and the erased all-ones word. The first separates granted reads from refused ones. The second separates autoboot from mere readability, and a reprogram issued under the read signature alone has to stay silent. The arbitrary word and the erase show that losing the signature revokes both rights. Copies are started both by command and by reset, and a write, an erase and a reprogram issued in the middle of a copy must leave the later readback and the next copy unchanged.

// File: rtl/fbc_pkg.sv
// Shared constants and types for the paged flash boot controller.
// Assumes 256-byte X-pages split into 64 four-byte Y-pages.
package fbc_pkg;
    localparam int XPAGE_BYTES    = 256;
    localparam int YPAGES_PER_X   = 64;
    localparam int YW             = 6;
    localparam int WORDS_PER_XPAGE = YPAGES_PER_X;

    // Byte 0 of the word lives in bits [7:0].
    localparam logic [31:0] READ_SIG = 32'h4030_0707;
    localparam logic [31:0] BOOT_SIG = 32'h4E31_5747;

    typedef enum logic [2:0] {
        ENG_SCAN  = 3'd0,
        ENG_WAIT  = 3'd1,
        ENG_CHECK = 3'd2,
        ENG_IDLE  = 3'd3,
        ENG_COPY  = 3'd4,
        ENG_DRAIN = 3'd5
    } eng_state_t;

    typedef struct packed {
        logic rd_ok;
        logic boot_ok;
    } caps_t;
endpackage

// File: rtl/fbc_flash_array.sv
// Word-wide flash storage model with one write port and two registered
// read ports. Contents are non-volatile, so the array has no reset; an
// erase sets every word to all ones in one cycle and wins over a write.
module fbc_flash_array #(
    parameter int XPAGES = 2,
    localparam int NWORDS = XPAGES * fbc_pkg::WORDS_PER_XPAGE,
    localparam int WW     = $clog2(NWORDS)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [WW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic          erase,
    input  logic [WW-1:0] a_addr,
    output logic [31:0]   a_dout,
    input  logic [WW-1:0] b_addr,
    output logic [31:0]   b_dout
);
    logic [31:0] mem [NWORDS];

    // Store a word or wipe the whole array.
    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < NWORDS; i++) begin
                mem[i] <= '1;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read ports: user reads (a) and boot engine (b).
    always_ff @(posedge clk) begin
        a_dout <= mem[a_addr];
        b_dout <= mem[b_addr];
    end
endmodule

// File: rtl/fbc_sig_decode.sv
// Holds the read and autoboot permissions decoded from flash word 0.
// Assumes the caller presents the word either on a write to word 0 or
// during the post-reset scan; an erase clear takes priority.
module fbc_sig_decode (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd_en,
    input  logic [31:0] upd_word,
    input  logic        clr,
    output logic        rd_ok,
    output logic        boot_ok
);
    import fbc_pkg::*;

    caps_t caps;

    // Update the permission flags from the presented word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            caps <= '0;
        end else if (clr) begin
            caps <= '0;
        end else if (upd_en) begin
            caps.rd_ok   <= (upd_word == READ_SIG);
            caps.boot_ok <= (upd_word == BOOT_SIG);
        end
    end

    assign rd_ok   = caps.rd_ok;
    assign boot_ok = caps.boot_ok;

    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ok && boot_ok));

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!rd_ok && !boot_ok));

    a_r5_reload_read: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !clr && upd_word == READ_SIG) |=> rd_ok);

    a_r5_reload_other: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !clr && upd_word != READ_SIG && upd_word != BOOT_SIG)
            |=> (!rd_ok && !boot_ok));
endmodule

// File: rtl/fbc_read_gate.sv
// Byte read path. It decides grant or refusal in the request cycle and
// delivers the result one cycle later. It assumes word_in is the
// registered array output for arr_addr.
module fbc_read_gate #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          allow,
    input  logic [31:0]   word_in,
    output logic [AW-3:0] arr_addr,
    output logic          rd_valid,
    output logic          rd_err,
    output logic [7:0]    rd_data
);
    logic       v_q;
    logic       err_q;
    logic [1:0] lane_q;

    assign arr_addr = rd_addr[AW-1:2];

    // Remember the outcome and byte lane of each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            err_q  <= 1'b0;
            lane_q <= 2'd0;
        end else begin
            v_q    <= rd_en && allow;
            err_q  <= rd_en && !allow;
            lane_q <= rd_addr[1:0];
        end
    end

    assign rd_valid = v_q;
    assign rd_err   = err_q;
    assign rd_data  = v_q ? word_in[{lane_q, 3'b000} +: 8] : 8'h00;

    a_r4_refused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_data == 8'h00 && !rd_valid));

    a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> ($past(rd_en) && !$past(allow)));

    a_r2_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_en) && $past(allow)));
endmodule

// File: rtl/fbc_copy_engine.sv
// Boot sequencer. After reset it scans word 0, then copies CFG_BYTES
// bytes from the flash into the SRAM port if autoboot is allowed, either
// at once or on a later start request. Assumes word_in is the registered
// array data for arr_addr.
module fbc_copy_engine #(
    parameter int AW        = 9,
    parameter int CFG_BYTES = 96,
    localparam int CW       = $clog2(CFG_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boot_ok,
    input  logic          start_req,
    input  logic [31:0]   word_in,
    output logic [AW-3:0] arr_addr,
    output logic          idle,
    output logic          scan_load,
    output logic          busy,
    output logic          done,
    output logic          cfg_we,
    output logic [CW-1:0] cfg_addr,
    output logic [7:0]    cfg_data
);
    import fbc_pkg::*;

    localparam logic [AW-1:0] LAST = AW'(CFG_BYTES - 1);

    eng_state_t    state;
    logic [AW-1:0] cnt;
    logic          we_q;
    logic [AW-1:0] addr_q;
    logic          done_q;

    // Sequence scan, decision, copy and drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ENG_SCAN;
            cnt   <= '0;
        end else begin
            case (state)
                ENG_SCAN:  state <= ENG_WAIT;
                ENG_WAIT:  state <= ENG_CHECK;
                ENG_CHECK: begin
                    cnt   <= '0;
                    state <= boot_ok ? ENG_COPY : ENG_IDLE;
                end
                ENG_IDLE: begin
                    if (start_req && boot_ok) begin
                        cnt   <= '0;
                        state <= ENG_COPY;
                    end
                end
                ENG_COPY: begin
                    cnt <= cnt + AW'(1);
                    if (cnt == LAST) begin
                        state <= ENG_DRAIN;
                    end
                end
                ENG_DRAIN: state <= ENG_IDLE;
                default:   state <= ENG_SCAN;
            endcase
        end
    end

    // Align the SRAM strobe and address with the array read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q   <= 1'b0;
            addr_q <= '0;
            done_q <= 1'b0;
        end else begin
            we_q   <= (state == ENG_COPY);
            addr_q <= cnt;
            done_q <= (state == ENG_DRAIN);
        end
    end

    assign arr_addr  = cnt[AW-1:2];
    assign idle      = (state == ENG_IDLE);
    assign scan_load = (state == ENG_WAIT);
    assign busy      = (state == ENG_COPY) || (state == ENG_DRAIN);
    assign done      = done_q;
    assign cfg_we    = we_q;
    assign cfg_addr  = addr_q[CW-1:0];
    assign cfg_data  = word_in[{addr_q[1:0], 3'b000} +: 8];

    a_r8_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> busy);

    a_r8_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_we) |-> (cfg_addr == '0));

    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && $past(cfg_we)) |-> (cfg_addr == $past(cfg_addr) + 1'b1));

    a_r9_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(cfg_we) && $past(cfg_addr) == CW'(CFG_BYTES - 1)));

    a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start_req && !boot_ok) |=> !busy);
endmodule

// File: rtl/flash_boot_ctrl.sv
// Top level of the paged flash boot controller. It wires the storage,
// the signature decoder, the read gate and the copy engine together, and
// lets configuration writes and erases through only while the engine is
// idle. XPAGES must be a power of two, at least 2; CFG_BYTES must be at
// least 2 and no larger than the flash.
module flash_boot_ctrl #(
    parameter int XPAGES    = 2,
    parameter int CFG_BYTES = 96,
    localparam int XW = $clog2(XPAGES),
    localparam int AW = $clog2(XPAGES * fbc_pkg::XPAGE_BYTES),
    localparam int WW = AW - 2,
    localparam int CW = $clog2(CFG_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pg_wr_en,
    input  logic [XW-1:0] pg_wr_xpage,
    input  logic [5:0]    pg_wr_ypage,
    input  logic [31:0]   pg_wr_data,
    input  logic          erase_req,
    input  logic          reprog_req,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_valid,
    output logic [7:0]    rd_data,
    output logic          rd_err,
    output logic          cfg_we,
    output logic [CW-1:0] cfg_addr,
    output logic [7:0]    cfg_data,
    output logic          boot_busy,
    output logic          boot_done
);
    logic          eng_idle;
    logic          scan_load;
    logic          wr_ok;
    logic          erase_ok;
    logic          word0_wr;
    logic [WW-1:0] wr_word;
    logic [WW-1:0] a_addr;
    logic [WW-1:0] b_addr;
    logic [31:0]   a_dout;
    logic [31:0]   b_dout;
    logic          rd_ok;
    logic          boot_ok;
    logic          dec_upd;
    logic [31:0]   dec_word;

    // Accept host commands only while the engine is idle.
    always_comb begin
        wr_ok    = pg_wr_en && eng_idle;
        erase_ok = erase_req && eng_idle;
        wr_word  = {pg_wr_xpage, pg_wr_ypage};
        word0_wr = wr_ok && (wr_word == '0);
        dec_upd  = scan_load || word0_wr;
        dec_word = scan_load ? b_dout : pg_wr_data;
    end

    fbc_flash_array #(.XPAGES(XPAGES)) u_array (
        .clk     (clk),
        .wr_en   (wr_ok),
        .wr_addr (wr_word),
        .wr_data (pg_wr_data),
        .erase   (erase_ok),
        .a_addr  (a_addr),
        .a_dout  (a_dout),
        .b_addr  (b_addr),
        .b_dout  (b_dout)
    );

    fbc_sig_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (dec_upd),
        .upd_word (dec_word),
        .clr      (erase_ok),
        .rd_ok    (rd_ok),
        .boot_ok  (boot_ok)
    );

    fbc_read_gate #(.AW(AW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .allow    (rd_ok),
        .word_in  (a_dout),
        .arr_addr (a_addr),
        .rd_valid (rd_valid),
        .rd_err   (rd_err),
        .rd_data  (rd_data)
    );

    fbc_copy_engine #(.AW(AW), .CFG_BYTES(CFG_BYTES)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_ok   (boot_ok),
        .start_req (reprog_req),
        .word_in   (b_dout),
        .arr_addr  (b_addr),
        .idle      (eng_idle),
        .scan_load (scan_load),
        .busy      (boot_busy),
        .done      (boot_done),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_data  (cfg_data)
    );

    a_r11_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        boot_busy |-> !wr_ok && !erase_ok);

    a_r7_scan_first: assert property (@(posedge clk) disable iff (!rst_n)
        scan_load |-> !boot_busy && !eng_idle);
endmodule

// File: tb/sim_flash_boot_ctrl.sv
module sim_flash_boot_ctrl;
    localparam int XP = 2;
    localparam int N  = 96;
    localparam int NB = XP * 256;
    localparam logic [31:0] RS = 32'h4030_0707;
    localparam logic [31:0] BS = 32'h4E31_5747;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_wr_en = 1'b0;
    logic [0:0]  pg_wr_xpage = '0;
    logic [5:0]  pg_wr_ypage = '0;
    logic [31:0] pg_wr_data = '0;
    logic        erase_req = 1'b0;
    logic        reprog_req = 1'b0;
    logic        rd_en = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic        rd_valid, rd_err, cfg_we, boot_busy, boot_done;
    logic [7:0]  rd_data, cfg_data;
    logic [6:0]  cfg_addr;

    int errors = 0;
    int checks = 0;
    string ctx = "reset";

    flash_boot_ctrl #(.XPAGES(XP), .CFG_BYTES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .pg_wr_en(pg_wr_en), .pg_wr_xpage(pg_wr_xpage),
        .pg_wr_ypage(pg_wr_ypage), .pg_wr_data(pg_wr_data), .erase_req(erase_req),
        .reprog_req(reprog_req), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_err(rd_err), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .boot_busy(boot_busy), .boot_done(boot_done)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", tag, ctx, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int x, input int y);
        return {8'(y + 8'h80), 8'(x + 8'h40), 8'(y * 2), 8'(8'h11 + y)};
    endfunction

    // Behavioural reference: byte image, flags and copy start cycle.
    logic [7:0] fl [NB];
    bit m_rd = 0, m_ab = 0;
    int s = -1000, p = 0, rel = 0;
    logic e_busy = 0, e_we = 0, e_done = 0, e_rv = 0, e_re = 0;
    logic [7:0] e_rdat = 0, e_cdat = 0;
    int e_caddr = 0;
    int we_cnt = 0, done_cnt = 0;

    initial for (int i = 0; i < NB; i++) fl[i] = 8'h00;

    always @(posedge clk) begin
        bit idle_prev;
        logic [31:0] w0;
        int base;
        p = p + 1;
        if (!rst_n) begin
            rel = 0; m_rd = 0; m_ab = 0; s = -1000;
            e_rv = 0; e_re = 0; e_rdat = 0;
        end else begin
            rel = rel + 1;
            idle_prev = (rel >= 4) && !((p - 1) >= s && (p - 1) <= s + N);
            e_rv = rd_en && m_rd;
            e_re = rd_en && !m_rd;
            e_rdat = e_rv ? fl[rd_addr] : 8'h00;
            if (rel == 2) begin
                w0 = {fl[3], fl[2], fl[1], fl[0]};
                m_rd = (w0 == RS); m_ab = (w0 == BS);
            end
            if (rel == 3 && m_ab) s = p;
            if (idle_prev) begin
                if (reprog_req && m_ab) s = p;
                if (erase_req) begin
                    for (int i = 0; i < NB; i++) fl[i] = 8'hFF;
                    m_rd = 0; m_ab = 0;
                end else if (pg_wr_en) begin
                    base = pg_wr_xpage * 256 + pg_wr_ypage * 4;
                    for (int k = 0; k < 4; k++) fl[base + k] = pg_wr_data[8*k +: 8];
                    if (base == 0) begin
                        m_rd = (pg_wr_data == RS); m_ab = (pg_wr_data == BS);
                    end
                end
            end
        end
        e_busy = (p >= s) && (p <= s + N);
        e_we = (p >= s + 1) && (p <= s + N);
        e_done = (p == s + N + 1);
        e_caddr = p - s - 1;
        e_cdat = e_we ? fl[e_caddr] : 8'h00;
    end

    // Compare every output against the reference on each falling edge.
    always @(negedge clk) begin
        if (p >= 1) begin
            check("R8 busy", 32'(boot_busy), 32'(e_busy));
            check("R8 sram strobe", 32'(cfg_we), 32'(e_we));
            if (e_we) begin
                check("R8 sram address", 32'(cfg_addr), 32'(e_caddr));
                check("R8 sram data", 32'(cfg_data), 32'(e_cdat));
            end
            check("R9 done", 32'(boot_done), 32'(e_done));
            check("R4 error pulse", 32'(rd_err), 32'(e_re));
            check("R2 read valid", 32'(rd_valid), 32'(e_rv));
            check("R2 read data", 32'(rd_data), 32'(e_rdat));
            if (cfg_we) we_cnt++;
            if (boot_done) done_cnt++;
        end
    end

    task automatic wr_word(input int x, input int y, input logic [31:0] d);
        pg_wr_en = 1; pg_wr_xpage = 1'(x); pg_wr_ypage = 6'(y); pg_wr_data = d;
        @(negedge clk);
        pg_wr_en = 0;
    endtask

    task automatic erase_pulse();
        erase_req = 1;
        @(negedge clk);
        erase_req = 0;
    endtask

    task automatic reprog();
        reprog_req = 1;
        @(negedge clk);
        reprog_req = 0;
    endtask

    task automatic rd_chk(input string tag, input int a, input bit ok, input logic [7:0] b);
        rd_en = 1; rd_addr = 9'(a);
        @(negedge clk);
        rd_en = 0;
        check({tag, " valid"}, 32'(rd_valid), 32'(ok));
        check({tag, " err"}, 32'(rd_err), 32'(!ok));
        check({tag, " data"}, 32'(rd_data), ok ? 32'(b) : 32'h0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog [%s] actual=hung expected=finished", ctx);
        summary();
    end

    initial begin
        int d0, w0c;
        repeat (4) @(negedge clk);
        check("reset busy", 32'(boot_busy), 0);
        check("reset strobe", 32'(cfg_we), 0);
        rst_n = 1;
        ctx = "R7 blank";
        repeat (3) @(negedge clk);
        check("R7 no copy from non-signature word", 32'(boot_busy), 0);
        repeat (3) @(negedge clk);

        ctx = "R6";
        erase_pulse();
        rd_chk("R6 read after erase", 0, 0, 0);
        rd_chk("R4 refused read", 300, 0, 0);

        ctx = "R1";
        for (int x = 0; x < XP; x++)
            for (int y = 0; y < 64; y++)
                wr_word(x, y, (x == 0 && y == 0) ? RS : pat(x, y));
        rd_chk("R2 signature byte0", 0, 1, 8'h07);
        rd_chk("R2 signature byte3", 3, 1, 8'h40);
        rd_chk("R1 byte lane 2", 256 + 22, 1, pat(1, 5)[23:16]);
        rd_chk("R1 byte lane 3", 63 * 4 + 3, 1, pat(0, 63)[31:24]);

        ctx = "R10";
        d0 = done_cnt; w0c = we_cnt;
        reprog();
        repeat (8) @(negedge clk);
        check("R10 no done", 32'(done_cnt), 32'(d0));
        check("R10 no sram write", 32'(we_cnt), 32'(w0c));

        ctx = "R3";
        wr_word(0, 0, BS);
        rd_chk("R3 read refused under autoboot", 8, 0, 0);

        ctx = "R8";
        d0 = done_cnt; w0c = we_cnt;
        reprog();
        ctx = "R11";
        wr_word(0, 5, 32'hDEAD_BEEF);
        erase_pulse();
        reprog();
        repeat (N + 6) @(negedge clk);
        check("R8 write count", 32'(we_cnt - w0c), 32'(N));
        check("R9 one done pulse", 32'(done_cnt - d0), 1);
        wr_word(0, 0, RS);
        rd_chk("R11 write during copy ignored", 20, 1, pat(0, 5)[7:0]);
        rd_chk("R11 erase during copy ignored", 21, 1, pat(0, 5)[15:8]);

        ctx = "R5";
        wr_word(0, 0, 32'h1234_5678);
        rd_chk("R5 other word revokes reads", 20, 0, 0);

        ctx = "R7";
        wr_word(0, 0, BS);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        d0 = done_cnt; w0c = we_cnt;
        @(negedge clk);
        check("R7 busy low first cycle", 32'(boot_busy), 0);
        @(negedge clk);
        check("R7 busy low second cycle", 32'(boot_busy), 0);
        @(negedge clk);
        check("R7 busy in third cycle", 32'(boot_busy), 1);
        repeat (N + 4) @(negedge clk);
        check("R7 boot copy count", 32'(we_cnt - w0c), 32'(N));
        check("R9 boot done", 32'(done_cnt - d0), 1);

        ctx = "R6 final";
        wr_word(0, 0, RS);
        rd_chk("R6 readable before erase", 1, 1, 8'h07);
        erase_pulse();
        rd_chk("R6 refused after erase", 1, 0, 0);
        reprog();
        repeat (4) @(negedge clk);
        check("R6 no copy after erase", 32'(boot_busy), 0);
        summary();
    end
endmodule